// File: doc/BRIEF.md
# Programmable Memory Pattern Sequencer

This block generates external memory bus cycles from microcode. A small pattern RAM, written through a load port, holds 32-bit words. When an access request arrives for one of eight banks, the sequencer starts at the word index given with the request. It steps forward one word per clock until it reaches a word marked as the end of the pattern. Each word sets that cycle's chip-select level, the byte-lane strobes and the transfer acknowledge.

A bank is served only when its per-bank ownership bit selects this sequencer. Only the accessed bank's chip-select is ever driven. Byte-lane strobes are further gated by a mask fixed when the request is accepted. The mask comes from the bank's port width, the transfer size and the two low address bits.

A per-bank stretch timer covers back-to-back accesses to the same bank. When it is enabled and such an access is waiting as the final word executes, the final word's outputs are held for 1 to 4 further clocks before the next pattern may start.

Word layout: bit 0 = chip-select on, bits 1..4 = strobe for byte lanes 0..3, bit 30 = acknowledge, bit 31 = end of pattern. Lane 0 is the most significant byte, which is the lowest byte address.

The controller has three states:
- **IDLE**: nothing is running.
- **RUN**: one pattern word is executed per clock.
- **HOLD**: the last word is stretched.

Its transitions are:
- IDLE→RUN when a request is accepted.
- RUN→RUN while the current word is not the last.
- RUN→IDLE on the last word when no stretch is due.
- RUN→HOLD on the last word when a stretch is due.
- HOLD→HOLD while the stretch counter is not zero.
- HOLD→IDLE when the counter reaches zero.

Top module: `mem_pattern_seq`

## Requirements
- R1: A request (`req_valid`) is accepted only in IDLE and only if `bank_owned[req_bank]` is 1. `busy` is high from the clock after acceptance until the pattern and any stretch end. A request for an unowned bank leaves `busy` low and all chip-selects high.
- R2: While a pattern runs, `cs_n[bank]` is low exactly when the current word's bit 0 is 1. Every other chip-select stays high.
- R3: The first word executed is the one at `req_start`, in the clock after acceptance. The index then increases by one per clock.
- R4: With no pattern running, `cs_n` is all ones, `bs_n` is all ones and `ack` is 0. This includes the state after reset.
- R5: `bs_n[i]` is low exactly when word bit 1+i is 1 and lane i is in the access mask. The lane width W is 1, 2 or 4 bytes for port code 0, 1 or 2/3. The transfer byte count N is 1, 2 or 4 for size code 0, 1 or 2/3. With offset O = addr mod W, lane i is in the mask when O ≤ i < min(O+N, W).
- R6: During RUN, `ack` equals bit 30 of the current word.
- R7: A word with bit 31 set executes in full in its cycle. Without a stretch, the block is back in IDLE (`busy` low) in the next clock.
- R8: Suppose the last word executes while `req_valid` is high for the same bank and `bank_hold_en` for that bank is 1. Then that word's chip-select and strobes are held, `busy` high and `ack` low, for 1 + `bank_hold_clks` field extra clocks before IDLE. Without the enable there is no stretch.
- R9: A waiting request for a different bank is not stretched. After the last word the block spends one IDLE clock and then starts the new pattern.
- R10: A write on the load port stores `load_data` at `load_addr`, and later patterns execute it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Pattern RAM write strobe |
| load_addr | input | 6 | Pattern RAM write index |
| load_data | input | 32 | Pattern word to store |
| bank_owned | input | 8 | Per bank: 1 = served by this sequencer |
| bank_port_size | input | 16 | Per bank 2-bit port width code (0=8, 1=16, 2/3=32 bits) |
| bank_hold_en | input | 8 | Per bank stretch-timer enable |
| bank_hold_clks | input | 16 | Per bank 2-bit stretch length (value+1 clocks) |
| req_valid | input | 1 | Access request |
| req_bank | input | 3 | Bank of the request |
| req_start | input | 6 | First pattern word index |
| req_size | input | 2 | Transfer size code (0=1, 1=2, 2/3=4 bytes) |
| req_addr | input | 2 | Low address bits of the access |
| busy | output | 1 | Pattern or stretch in progress |
| cs_n | output | 8 | Active-low chip-selects |
| bs_n | output | 4 | Active-low byte-lane strobes, lane 0 = MSB |
| ack | output | 1 | Transfer acknowledge from the pattern word |

## Verification
The hardest situation to reach is the stretch. It needs a same-bank request to be waiting at exactly the clock the last word executes, and that request must not be accepted early. The stimulus therefore keeps `req_valid` high for the whole pattern, which the busy gate ignores. It sweeps all four stretch lengths and then checks the re-acceptance that follows. A second sequence swaps the waiting request to another bank in mid-pattern, showing that no stretch occurs.

// File: rtl/mps_pkg.sv
package mps_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = 4;
    localparam int W_CS    = 0;
    localparam int W_BS_LO = 1;
    localparam int W_ACK   = 30;
    localparam int W_LAST  = 31;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;
endpackage

// File: rtl/mps_pattern_ram.sv
module mps_pattern_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/mps_lane_mask.sv
module mps_lane_mask #(
    parameter int LANE_CNT = 4
) (
    input  logic [1:0]          port_code,
    input  logic [1:0]          size_code,
    input  logic [1:0]          addr_lo,
    output logic [LANE_CNT-1:0] lane_en
);
    logic [2:0] port_bytes;
    logic [2:0] xfer_bytes;
    logic [2:0] first_lane;
    logic [2:0] span_end;
    logic [2:0] end_lane;

    always_comb begin
        unique case (port_code)
            2'd0:    port_bytes = 3'd1;
            2'd1:    port_bytes = 3'd2;
            default: port_bytes = 3'd4;
        endcase
        unique case (size_code)
            2'd0:    xfer_bytes = 3'd1;
            2'd1:    xfer_bytes = 3'd2;
            default: xfer_bytes = 3'd4;
        endcase
        first_lane = {1'b0, addr_lo} & (port_bytes - 3'd1);
        span_end   = first_lane + xfer_bytes;
        end_lane   = (span_end > port_bytes) ? port_bytes : span_end;
    end

    for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
        assign lane_en[g] = (3'(g) >= first_lane) && (3'(g) < end_lane);
    end
endmodule

// File: rtl/mps_hold_timer.sv
module mps_hold_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (load)             cnt_q <= load_val;
        else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R8: the stretch counter steps down by exactly one per held clock
    assert_timer_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mem_pattern_seq.sv
module mem_pattern_seq
    import mps_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int RAM_DEPTH  = 64,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int IDX_W     = $clog2(RAM_DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic [IDX_W-1:0]       load_addr,
    input  logic [WORD_W-1:0]      load_data,
    input  logic [NUM_BANKS-1:0]   bank_owned,
    input  logic [2*NUM_BANKS-1:0] bank_port_size,
    input  logic [NUM_BANKS-1:0]   bank_hold_en,
    input  logic [2*NUM_BANKS-1:0] bank_hold_clks,
    input  logic                   req_valid,
    input  logic [BANK_W-1:0]      req_bank,
    input  logic [IDX_W-1:0]       req_start,
    input  logic [1:0]             req_size,
    input  logic [1:0]             req_addr,
    output logic                   busy,
    output logic [NUM_BANKS-1:0]   cs_n,
    output logic [LANES-1:0]       bs_n,
    output logic                   ack
);
    seq_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [BANK_W-1:0] bank_q;
    logic [LANES-1:0]  mask_q, mask_w;
    logic [WORD_W-1:0] rd_word, held_q, cur_word;
    logic              accept, word_last, stretch_due;
    logic              tmr_load, tmr_done;
    logic [1:0]        tmr_val;

    mps_pattern_ram #(.DEPTH(RAM_DEPTH), .WIDTH(WORD_W)) u_ram (
        .clk     (clk),
        .wr_en   (load_en),
        .wr_addr (load_addr),
        .wr_data (load_data),
        .rd_addr (idx_q),
        .rd_data (rd_word)
    );

    mps_lane_mask #(.LANE_CNT(LANES)) u_mask (
        .port_code (bank_port_size[2*req_bank +: 2]),
        .size_code (req_size),
        .addr_lo   (req_addr),
        .lane_en   (mask_w)
    );

    mps_hold_timer #(.CNT_W(2)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (state_q == ST_HOLD),
        .done     (tmr_done)
    );

    assign accept      = (state_q == ST_IDLE) && req_valid && bank_owned[req_bank];
    assign word_last   = rd_word[W_LAST];
    assign stretch_due = req_valid && (req_bank == bank_q) && bank_hold_en[bank_q];
    assign tmr_load    = (state_q == ST_RUN) && word_last && stretch_due;
    assign tmr_val     = bank_hold_clks[2*bank_q +: 2];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RUN;
            ST_RUN:  if (word_last) state_d = stretch_due ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (tmr_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // request context and word pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            bank_q <= '0;
            mask_q <= '0;
            held_q <= '0;
        end else begin
            if (accept) begin
                idx_q  <= req_start;
                bank_q <= req_bank;
                mask_q <= mask_w;
            end else if (state_q == ST_RUN) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_RUN && word_last) held_q <= rd_word;
        end
    end

    // outputs
    always_comb begin
        cur_word = (state_q == ST_HOLD) ? held_q : rd_word;
        busy     = (state_q != ST_IDLE);
        cs_n     = '1;
        bs_n     = '1;
        ack      = 1'b0;
        if (state_q != ST_IDLE) begin
            if (cur_word[W_CS]) cs_n[bank_q] = 1'b0;
            bs_n = ~(cur_word[W_BS_LO +: LANES] & mask_q);
        end
        if (state_q == ST_RUN) ack = rd_word[W_ACK];
    end

    // R2: at most one chip-select is active
    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R4: nothing is driven while not busy
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n && &bs_n && !ack));
    // R1: busy only rises after a request was presented
    assert_busy_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    // R5: strobes never leave the lanes the access mask allows
    assert_lane_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~bs_n & ~mask_q) == '0));
    // R6: acknowledge only while words execute
    assert_ack_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (state_q == ST_RUN));
    // R8: outputs frozen during the stretch
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> ($stable(cs_n) && $stable(bs_n)));
endmodule

// File: tb/mem_pattern_seq_test.sv
module mem_pattern_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [7:0]  bank_owned = 8'b1101_1011;
    logic [15:0] bank_port_size = 16'hAAAA;
    logic [7:0]  bank_hold_en = '0;
    logic [15:0] bank_hold_clks = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_bank = '0;
    logic [5:0]  req_start = '0;
    logic [1:0]  req_size = 2'd2;
    logic [1:0]  req_addr = '0;
    logic        busy, ack;
    logic [7:0]  cs_n;
    logic [3:0]  bs_n;

    int tests = 0;
    int fails = 0;
    logic [31:0] img [64];

    always #2 clk = ~clk;

    mem_pattern_seq uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkw(bit last, bit ackb, logic [3:0] lanes, bit cs);
        return {last, ackb, 25'b0, lanes, cs};
    endfunction

    function automatic bit lane_on(int port, int sz, int a, int lane);
        int w = (port == 0) ? 1 : (port == 1) ? 2 : 4;
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        int o = a % w;
        return (lane >= o) && (lane < o + n) && (lane < w);
    endfunction

    task automatic load_word(int a, logic [31:0] w);
        load_en = 1'b1; load_addr = 6'(a); load_data = w; img[a] = w;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic start_req(int b, int s, int sz, int a);
        req_valid = 1'b1; req_bank = 3'(b); req_start = 6'(s);
        req_size = 2'(sz); req_addr = 2'(a);
        @(negedge clk);
    endtask

    task automatic check_pattern(int b, int s, int port, int sz, int a);
        int i = s;
        bit fin = 0;
        while (!fin) begin
            logic [31:0] w = img[i];
            logic [7:0]  ecs = 8'hFF;
            logic [3:0]  ebs = 4'hF;
            if (w[0]) ecs[b] = 1'b0;
            for (int l = 0; l < 4; l++) if (w[1+l] && lane_on(port, sz, a, l)) ebs[l] = 1'b0;
            chk("R2", 32'(cs_n), 32'(ecs), "chip select");
            chk("R5", 32'(bs_n), 32'(ebs), "byte strobes");
            chk("R6", 32'(ack), 32'(w[30]), "ack");
            chk("R3", 32'(busy), 32'd1, "busy in word");
            if (w[31]) fin = 1;
            else begin i = (i + 1) % 64; @(negedge clk); end
        end
    endtask

    task automatic check_idle(string req);
        chk(req, 32'(busy), 32'd0, "busy idle");
        chk(req, 32'(cs_n), 32'hFF, "cs idle");
        chk(req, 32'(bs_n), 32'hF, "bs idle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R4");
        chk("R4", 32'(ack), 32'd0, "ack after reset");

        // R10: patterns written through the load port
        load_word(0,  mkw(0, 0, 4'b0000, 1));
        load_word(1,  mkw(0, 0, 4'b1111, 1));
        load_word(2,  mkw(0, 1, 4'b1010, 1));
        load_word(3,  mkw(1, 0, 4'b0101, 0));
        load_word(10, mkw(1, 1, 4'b1111, 1));
        load_word(20, mkw(0, 1, 4'b1100, 1));
        load_word(21, mkw(1, 1, 4'b0011, 1));
        load_word(63, mkw(0, 0, 4'b1001, 1));

        // bank sweep: R1, R2, R3, R7
        for (int b = 0; b < 8; b++) begin
            start_req(b, 0, 2, 0);
            req_valid = 1'b0;
            if (bank_owned[b]) begin
                check_pattern(b, 0, 2, 2, 0);
                @(negedge clk);
                check_idle("R7");
            end else begin
                check_idle("R1");
                @(negedge clk);
                check_idle("R1");
            end
        end

        // R3/R10: index wraps from the top word to word 0
        start_req(1, 63, 2, 0);
        req_valid = 1'b0;
        check_pattern(1, 63, 2, 2, 0);
        @(negedge clk);
        check_idle("R7");

        // R5: lane mask sweep on bank 0
        for (int p = 0; p < 3; p++) begin
            bank_port_size[1:0] = 2'(p);
            for (int sz = 0; sz < 3; sz++) begin
                for (int a = 0; a < 4; a++) begin
                    start_req(0, 10, sz, a);
                    req_valid = 1'b0;
                    check_pattern(0, 10, p, sz, a);
                    @(negedge clk);
                    check_idle("R5");
                end
            end
        end
        bank_port_size[1:0] = 2'd2;

        // R8: same-bank stretch, all lengths
        bank_hold_en[3] = 1'b1;
        for (int c = 0; c < 4; c++) begin
            bank_hold_clks[7:6] = 2'(c);
            start_req(3, 20, 2, 0);
            check_pattern(3, 20, 2, 2, 0);
            for (int k = 0; k <= c; k++) begin
                @(negedge clk);
                chk("R8", 32'(cs_n), 32'hF7, "held cs");
                chk("R8", 32'(bs_n), 32'hC, "held bs");
                chk("R8", 32'(busy), 32'd1, "busy in stretch");
                chk("R8", 32'(ack), 32'd0, "ack in stretch");
            end
            @(negedge clk);
            check_idle("R8");
            @(negedge clk);
            req_valid = 1'b0;
            check_pattern(3, 20, 2, 2, 0);
            @(negedge clk);
            check_idle("R8");
        end

        // R9: waiting request for another bank is not stretched
        bank_hold_clks[7:6] = 2'd3;
        start_req(3, 20, 2, 0);
        req_bank = 3'd4;
        check_pattern(3, 20, 2, 2, 0);
        @(negedge clk);
        check_idle("R9");
        @(negedge clk);
        req_valid = 1'b0;
        check_pattern(4, 20, 2, 2, 0);
        @(negedge clk);
        check_idle("R9");

        // R8: same bank but stretch disabled
        bank_hold_en[3] = 1'b0;
        start_req(3, 20, 2, 0);
        check_pattern(3, 20, 2, 2, 0);
        @(negedge clk);
        check_idle("R8");
        @(negedge clk);
        req_valid = 1'b0;
        check_pattern(3, 20, 2, 2, 0);
        @(negedge clk);
        check_idle("R8");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule